// File: doc/BRIEF.md
# Endian-Selectable Load/Store Byte Lane Aligner

This block sits between a 32-bit register file and a memory bus that is address invariant: the byte at address offset 0 always travels on lane [7:0], and the byte at offset 3 always travels on lane [31:24]. Because the bus never reorders bytes, every endian conversion happens here. One request carries the access size, the two low address bits, a signed/unsigned flag, the register value to be stored and the 32-bit word read from the bus. The block returns the store data steered onto the bus lanes, the matching byte enables, the load value extracted and extended to 32 bits, and a misalignment flag.

A mode input selects between little-endian and big-endian order. Big-endian mode reverses the byte order inside a word or half-word, so the most significant register byte lands at the lowest address. Single bytes always use lane k for offset k, whatever the mode. Instruction fetch does not pass through this block. The block sets no mode of its own: the caller drives the mode bit from the processor status.

Requests enter on a valid/ready handshake, and results leave on a second valid/ready handshake through a single output register. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its result appears on the next cycle and stays unchanged while `rsp_valid` is high and `rsp_ready` is low. `req_ready` is high when the output register is empty or is being drained in the same cycle, so the block runs at one request per cycle when there is no back-pressure.

Top module: `lane_aligner`

## Requirements
- R1: Size codes are 0 for a byte, 1 for a half-word and 2 for a word. Code 3 is illegal and is always reported as misaligned.
- R2: A half-word with address bit 0 set, or a word with a nonzero address, is misaligned. A misaligned request sets `rsp_misaligned`, drives `rsp_byte_en` to 4'b0000, drives `rsp_lanes` to zero and returns a load value of zero.
- R3: Byte enables are 4'b1111 for a word, 4'b0011 for a half-word at offset 0, 4'b1100 for a half-word at offset 2, and a single bit k for a byte at offset k. Lanes that are not enabled carry zero.
- R4: In little-endian mode (`big_endian`=0), a stored word appears unchanged on the bus. A half-word at offset 2h puts register bits [15:0] on lanes [16h+15:16h] in natural order. A byte at offset k puts register bits [7:0] on lane k.
- R5: In big-endian mode, a stored word is byte-reversed: register 0x01020304 appears as 0x04030201 on the bus. A half-word is byte-reversed within its two lanes: 0x0304 at offset 0 puts 0x03 on lane [7:0] and 0x04 on lane [15:8]. A byte at offset k still uses lane k.
- R6: Loads apply the inverse of the store mapping for the same mode, size and offset. Storing a value and then loading the bus word it produced returns the original register bits of that size.
- R7: For byte and half-word loads, `req_signed`=1 copies the top bit of the loaded item into all upper bits, and `req_signed`=0 fills them with zeros. A word load ignores `req_signed`.
- R8: The result of a request taken on clock edge n is shown on the outputs from edge n+1, with `rsp_valid` high.
- R9: While `rsp_valid` is high and `rsp_ready` is low, all response outputs hold their values and `req_ready` is low.
- R10: After reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word, 3 illegal |
| req_addr | input | 2 | Byte offset within the 32-bit bus word |
| req_signed | input | 1 | Sign-extend byte and half-word loads |
| req_big_endian | input | 1 | 1 selects big-endian lane order for this request |
| req_store_data | input | 32 | Register value to be stored |
| req_bus_rdata | input | 32 | Bus word read for a load |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_lanes | output | 32 | Store data placed on bus lanes |
| rsp_byte_en | output | 4 | Store byte enables, bit k for lane k |
| rsp_load_value | output | 32 | Extracted and extended load result |
| rsp_misaligned | output | 1 | Request is misaligned or has an illegal size |

## Verification
Random requests cover every size code, offset, mode and sign flag. Each has a register value and a bus word with distinct bytes, so a lane swap or a missing byte reversal gives a different value. Directed cases use the reference value 0x01020304 in both modes at each offset. Compared with little-endian mode, they separate word reversal, half-word reversal and the byte case, which must not change. Loaded items whose top bit is set tell sign extension apart from zero fill. Random back-pressure on `rsp_ready` checks that a stalled result holds steady and that no new request is taken while it waits.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lane_align_check.sv
module lane_align_check #(
  parameter int LANES = 4,
  localparam int AW = $clog2(LANES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chk_en,
  input  lane_align_pkg::acc_size_e size,
  input  logic [AW-1:0]            addr,
  output logic                     misaligned
);
  import lane_align_pkg::*;

  always_comb begin
    unique case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = addr[0];
      SZ_WORD: misaligned = (addr != '0);
      default: misaligned = 1'b1;
    endcase
  end

  // R1
  illegal_size_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && size == SZ_BAD) |-> misaligned);

  // R2
  byte_never_misaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && size == SZ_BYTE) |-> !misaligned);
endmodule

// File: rtl/lane_store_steer.sv
module lane_store_steer #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = BYTE_W * LANES,
  localparam int AW     = $clog2(LANES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chk_en,
  input  lane_align_pkg::acc_size_e size,
  input  logic [AW-1:0]            addr,
  input  logic                     big_endian,
  input  logic                     misaligned,
  input  logic [DATA_W-1:0]        store_data,
  output logic [DATA_W-1:0]        lanes,
  output logic [LANES-1:0]         byte_en
);
  import lane_align_pkg::*;

  logic [DATA_W-1:0]   word_rev;
  logic [2*BYTE_W-1:0] half_item;
  logic [DATA_W-1:0]   spread;
  logic [DATA_W-1:0]   lane_mask;

  // full byte reversal of the register value
  for (genvar g = 0; g < LANES; g++) begin : g_rev
    assign word_rev[g*BYTE_W +: BYTE_W] = store_data[(LANES-1-g)*BYTE_W +: BYTE_W];
  end

  assign half_item = big_endian ? {store_data[BYTE_W-1:0], store_data[2*BYTE_W-1:BYTE_W]}
                                : store_data[2*BYTE_W-1:0];

  always_comb begin
    spread  = '0;
    byte_en = '0;
    if (!misaligned) begin
      unique case (size)
        SZ_BYTE: begin
          spread  = {LANES{store_data[BYTE_W-1:0]}};
          byte_en = LANES'(1) << addr;
        end
        SZ_HALF: begin
          spread  = {(LANES/2){half_item}};
          byte_en = LANES'(3) << addr;
        end
        SZ_WORD: begin
          spread  = big_endian ? word_rev : store_data;
          byte_en = '1;
        end
        default: begin
          spread  = '0;
          byte_en = '0;
        end
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign lane_mask[g*BYTE_W +: BYTE_W] = {BYTE_W{byte_en[g]}};
  end

  assign lanes = spread & lane_mask;

  // R2
  misaligned_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && misaligned) |-> (byte_en == '0 && lanes == '0));

  // R3
  byte_one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && size == SZ_BYTE) |-> $countones(byte_en) == 1);

  // R3
  word_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && size == SZ_WORD && !misaligned) |-> byte_en == '1);

  // R5
  be_word_msb_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && big_endian && size == SZ_WORD && !misaligned)
      |-> lanes[BYTE_W-1:0] == store_data[DATA_W-1 -: BYTE_W]);
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = BYTE_W * LANES,
  localparam int AW     = $clog2(LANES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chk_en,
  input  lane_align_pkg::acc_size_e size,
  input  logic [AW-1:0]            addr,
  input  logic                     big_endian,
  input  logic                     signed_ld,
  input  logic                     misaligned,
  input  logic [DATA_W-1:0]        bus_rdata,
  output logic [DATA_W-1:0]        value
);
  import lane_align_pkg::*;

  logic [DATA_W-1:0]   word_rev;
  logic [BYTE_W-1:0]   byte_sel;
  logic [2*BYTE_W-1:0] half_raw;
  logic [2*BYTE_W-1:0] half_sel;
  logic [AW-1:0]       half_base;

  for (genvar g = 0; g < LANES; g++) begin : g_rev
    assign word_rev[g*BYTE_W +: BYTE_W] = bus_rdata[(LANES-1-g)*BYTE_W +: BYTE_W];
  end

  // even base keeps the half-word select in range
  assign half_base = {addr[AW-1:1], 1'b0};
  assign byte_sel  = bus_rdata[int'(addr)*BYTE_W +: BYTE_W];
  assign half_raw  = bus_rdata[int'(half_base)*BYTE_W +: 2*BYTE_W];
  assign half_sel  = big_endian ? {half_raw[BYTE_W-1:0], half_raw[2*BYTE_W-1:BYTE_W]}
                                : half_raw;

  always_comb begin
    value = '0;
    if (!misaligned) begin
      unique case (size)
        SZ_BYTE: value = {{(DATA_W-BYTE_W){signed_ld & byte_sel[BYTE_W-1]}}, byte_sel};
        SZ_HALF: value = {{(DATA_W-2*BYTE_W){signed_ld & half_sel[2*BYTE_W-1]}}, half_sel};
        SZ_WORD: value = big_endian ? word_rev : bus_rdata;
        default: value = '0;
      endcase
    end
  end

  // R7
  unsigned_byte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !misaligned && size == SZ_BYTE && !signed_ld)
      |-> value[DATA_W-1:BYTE_W] == '0);

  // R6
  le_word_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !misaligned && size == SZ_WORD && !big_endian) |-> value == bus_rdata);

  // R2
  misaligned_zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && misaligned) |-> value == '0);
endmodule

// File: rtl/lane_aligner.sv
module lane_aligner #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = BYTE_W * LANES,
  localparam int AW     = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_size,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_signed,
  input  logic              req_big_endian,
  input  logic [DATA_W-1:0] req_store_data,
  input  logic [DATA_W-1:0] req_bus_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_lanes,
  output logic [LANES-1:0]  rsp_byte_en,
  output logic [DATA_W-1:0] rsp_load_value,
  output logic              rsp_misaligned
);
  import lane_align_pkg::*;

  typedef struct packed {
    logic [DATA_W-1:0] lanes;
    logic [LANES-1:0]  byte_en;
    logic [DATA_W-1:0] load_value;
    logic              misaligned;
  } rsp_t;

  acc_size_e size_e;
  logic      mis_c;
  rsp_t      nxt, held;
  logic      take;

  assign size_e    = acc_size_e'(req_size);
  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  lane_align_check #(.LANES(LANES)) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_en     (req_valid),
    .size       (size_e),
    .addr       (req_addr),
    .misaligned (mis_c)
  );

  lane_store_steer #(.BYTE_W(BYTE_W), .LANES(LANES)) u_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_en     (req_valid),
    .size       (size_e),
    .addr       (req_addr),
    .big_endian (req_big_endian),
    .misaligned (mis_c),
    .store_data (req_store_data),
    .lanes      (nxt.lanes),
    .byte_en    (nxt.byte_en)
  );

  lane_load_extract #(.BYTE_W(BYTE_W), .LANES(LANES)) u_extract (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_en     (req_valid),
    .size       (size_e),
    .addr       (req_addr),
    .big_endian (req_big_endian),
    .signed_ld  (req_signed),
    .misaligned (mis_c),
    .bus_rdata  (req_bus_rdata),
    .value      (nxt.load_value)
  );

  assign nxt.misaligned = mis_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      held      <= '0;
    end else begin
      if (take) begin
        rsp_valid <= 1'b1;
        held      <= nxt;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assign rsp_lanes      = held.lanes;
  assign rsp_byte_en    = held.byte_en;
  assign rsp_load_value = held.load_value;
  assign rsp_misaligned = held.misaligned;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_lanes) && $stable(rsp_byte_en)
                                   && $stable(rsp_load_value) && $stable(rsp_misaligned)));

  // R8
  accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R9
  stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/test_lane_aligner.sv
module test_lane_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_size = 2'd0;
  logic [1:0]  req_addr = 2'd0;
  logic        req_signed = 1'b0;
  logic        req_big_endian = 1'b0;
  logic [31:0] req_store_data = '0;
  logic [31:0] req_bus_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_lanes;
  logic [3:0]  rsp_byte_en;
  logic [31:0] rsp_load_value;
  logic        rsp_misaligned;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lane_aligner i_lane_aligner (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_addr(req_addr), .req_signed(req_signed),
    .req_big_endian(req_big_endian), .req_store_data(req_store_data),
    .req_bus_rdata(req_bus_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_lanes(rsp_lanes), .rsp_byte_en(rsp_byte_en),
    .rsp_load_value(rsp_load_value), .rsp_misaligned(rsp_misaligned)
  );

  function automatic bit m_err(input logic [1:0] sz, input logic [1:0] a);
    if (sz == 2'd3) return 1'b1;
    if (sz == 2'd1) return a[0];
    if (sz == 2'd2) return a != 2'd0;
    return 1'b0;
  endfunction

  function automatic logic [3:0] m_be(input logic [1:0] sz, input logic [1:0] a);
    if (m_err(sz, a)) return 4'b0000;
    case (sz)
      2'd0:    return 4'b0001 << a;
      2'd1:    return (a == 2'd0) ? 4'b0011 : 4'b1100;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] m_lanes(input logic [1:0] sz, input logic [1:0] a,
                                          input bit be, input logic [31:0] d);
    logic [31:0] r = '0;
    logic [15:0] h;
    if (m_err(sz, a)) return '0;
    case (sz)
      2'd0: r[8*a +: 8] = d[7:0];
      2'd1: begin
        h = be ? {d[7:0], d[15:8]} : d[15:0];
        if (a == 2'd0) r[15:0] = h; else r[31:16] = h;
      end
      default: r = be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] m_load(input logic [1:0] sz, input logic [1:0] a,
                                         input bit be, input bit sg, input logic [31:0] b);
    logic [7:0]  x;
    logic [15:0] h;
    if (m_err(sz, a)) return '0;
    case (sz)
      2'd0: begin
        x = b[8*a +: 8];
        return (sg && x[7]) ? {24'hFFFFFF, x} : {24'h0, x};
      end
      2'd1: begin
        h = (a == 2'd0) ? b[15:0] : b[31:16];
        if (be) h = {h[7:0], h[15:8]};
        return (sg && h[15]) ? {16'hFFFF, h} : {16'h0, h};
      end
      default: return be ? {b[7:0], b[15:8], b[23:16], b[31:24]} : b;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one request; stall>0 holds rsp_ready low for that many cycles
  task automatic apply(input logic [1:0] sz, input logic [1:0] a, input bit be,
                       input bit sg, input logic [31:0] d, input logic [31:0] b,
                       input int stall);
    logic [31:0] sl, sv;
    logic [3:0]  sb;
    @(negedge clk);
    req_valid = 1'b1; req_size = sz; req_addr = a; req_big_endian = be;
    req_signed = sg; req_store_data = d; req_bus_rdata = b;
    rsp_ready = (stall == 0);
    chk("R9", "req_ready before accept", {31'h0, req_ready}, 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    vectors++;
    // R8: result visible one edge after acceptance
    chk("R8", "rsp_valid", {31'h0, rsp_valid}, 32'h1);
    chk("R1/R2 misaligned", "flag", {31'h0, rsp_misaligned}, {31'h0, m_err(sz, a)});
    chk("R3", "byte_en", {28'h0, rsp_byte_en}, {28'h0, m_be(sz, a)});
    chk(be ? "R5 store" : "R4 store", "lanes", rsp_lanes, m_lanes(sz, a, be, d));
    chk("R6/R7 load", "value", rsp_load_value, m_load(sz, a, be, sg, b));
    if (stall > 0) begin
      sl = rsp_lanes; sb = rsp_byte_en; sv = rsp_load_value;
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        chk("R9", "held valid", {31'h0, rsp_valid}, 32'h1);
        chk("R9", "req_ready low", {31'h0, req_ready}, 32'h0);
        chk("R9", "held lanes", rsp_lanes, sl);
        chk("R9", "held byte_en", {28'h0, rsp_byte_en}, {28'h0, sb});
        chk("R9", "held load", rsp_load_value, sv);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      chk("R9", "drained", {31'h0, rsp_valid}, 32'h0);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1999;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
    chk("R10", "req_ready in reset", {31'h0, req_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);

    // R5 directed: reference value, big-endian
    apply(2'd2, 2'd0, 1'b1, 1'b0, 32'h01020304, 32'h04030201, 0);
    apply(2'd1, 2'd0, 1'b1, 1'b0, 32'h00000304, 32'h00000403, 0);
    apply(2'd1, 2'd2, 1'b1, 1'b0, 32'h00000304, 32'h04030000, 0);
    for (int k = 0; k < 4; k++)
      apply(2'd0, 2'(k), 1'b1, 1'b0, 32'h00000004, 32'h04040404, 0);
    // R4 directed: same values little-endian
    apply(2'd2, 2'd0, 1'b0, 1'b0, 32'h01020304, 32'h01020304, 0);
    apply(2'd1, 2'd2, 1'b0, 1'b0, 32'h00000304, 32'h03040000, 0);
    // R7 directed: sign vs zero fill
    apply(2'd0, 2'd3, 1'b0, 1'b1, 32'h0, 32'h80000000, 0);
    apply(2'd0, 2'd3, 1'b0, 1'b0, 32'h0, 32'h80000000, 0);
    apply(2'd1, 2'd2, 1'b1, 1'b1, 32'h0, 32'h00800000, 0);
    apply(2'd2, 2'd0, 1'b0, 1'b1, 32'h0, 32'h80000001, 0);
    // R1 / R2 directed
    apply(2'd3, 2'd0, 1'b0, 1'b0, 32'hDEADBEEF, 32'h12345678, 0);
    apply(2'd1, 2'd1, 1'b1, 1'b1, 32'hDEADBEEF, 32'h12345678, 0);
    apply(2'd2, 2'd2, 1'b0, 1'b0, 32'hDEADBEEF, 32'h12345678, 2);

    // random mix with back-pressure
    for (int n = 0; n < 400; n++)
      apply(2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
            $urandom, $urandom, ($urandom % 4 == 0) ? int'($urandom % 3) + 1 : 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule